// File: doc/BRIEF.md
# Victim Line Buffer with Swap

This block is a small fully-associative store that sits next to a direct-mapped primary cache and holds lines the primary cache has recently thrown out. Each entry keeps the complete line address (tag and set index together), because an entry can come from any primary set. When the primary cache evicts a line, it hands the line to the insert port. The buffer then places it in an empty slot or, when every slot is occupied, over its least-recently-used entry.

When the primary cache misses, it presents the line address it wants on the lookup port. It also presents the line it is about to displace from that set. On a hit, the requested line comes back on the swap-out data port one cycle later. The displaced primary line takes over the exact slot the hit line occupied, so a hit never throws out the least-recently-used entry and no memory fetch is needed. On a miss, nothing inside the buffer changes and the requester goes to memory.

Recency is tracked as a permutation of per-slot ages. An entry that is written, whether by an insert or by a swap, becomes the most recently used.

Top module: `victim_buf`

## Requirements
- R1: After reset, every slot is empty, `respValid` is low, and any lookup misses.
- R2: A lookup presented in cycle n produces `respValid` high in cycle n+1 with `respHit` set exactly when a valid slot holds the full line address `lkAddr`; with no lookup, `respValid` is low in the next cycle.
- R3: On a hit, `respData` carries the data stored with the matching line; on a miss, `respData` is zero.
- R4: On a hit with `dispValid` high, the displaced line (`dispAddr`, `dispData`) is written into the slot of the hit line; afterwards, the displaced address hits with its data and the former hit address misses.
- R5: On a hit with `dispValid` low, the hit line is removed and its slot becomes empty.
- R6: An insert fills an empty slot while one exists, so ENTRIES distinct inserts after reset all remain present.
- R7: With all slots full, an insert overwrites the least-recently-used entry; an entry written by an insert or by a swap becomes the most recently used.
- R8: A lookup hit never removes any entry other than the hit line itself, so the least-recently-used entry stays present.
- R9: A lookup miss changes neither the contents nor the recency order.
- R10: When `insValid` and `lkValid` are high in the same cycle, only the lookup is performed and the insert is dropped.
- R11: With all slots full and two lines A and B conflicting in the primary cache, the sequence "B misses, A inserted, then alternating swaps" evicts only the oldest entry once, and every later alternating lookup hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| insValid | input | 1 | Insert a line evicted from the primary cache |
| insAddr | input | ADDR_W | Full line address of the inserted line |
| insData | input | DATA_W | Data of the inserted line |
| lkValid | input | 1 | Lookup request after a primary miss |
| lkAddr | input | ADDR_W | Full line address being searched |
| dispValid | input | 1 | The primary set holds a line that a hit would displace |
| dispAddr | input | ADDR_W | Full line address of the displaced primary line |
| dispData | input | DATA_W | Data of the displaced primary line |
| respValid | output | 1 | Lookup response valid, one cycle after `lkValid` |
| respHit | output | 1 | Lookup found the line |
| respData | output | DATA_W | Swapped-out line data on a hit, zero on a miss |

## Verification
The assertions check the following on every cycle: the response timing, agreement between the match vector and the reported hit, zero data on a miss, uniqueness of a match, the occupancy effect of an empty-handed hit, and the fact that a miss leaves the occupancy unchanged. Some behaviours show up only through sequences at the ports, so only the scoreboard scenarios can demonstrate them. These are the replacement order, the most-recently-used promotion after inserts and swaps, the survival of the oldest entry across a hit, the dropped insert on a collision, and the ping-pong trace of two conflicting lines. A recency-ordered reference list in the bench predicts these.

// File: rtl/victim_pkg.sv
package victim_pkg;

  // Per-cycle commands from control to the storage datapath.
  typedef struct packed {
    logic write;      // write one slot this cycle
    logic writeValid; // valid bit written into that slot
    logic useDisp;    // source is the displaced primary line (else insert port)
    logic respond;    // load a lookup response
    logic hit;        // the lookup hit
  } vcStrobe_t;

endpackage

// File: rtl/victim_ctrl.sv
module victim_ctrl
  import victim_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               insValid,
  input  logic               lkValid,
  input  logic               dispValid,
  input  logic [ENTRIES-1:0] hitVec,
  input  logic [ENTRIES-1:0] validVec,
  output vcStrobe_t          strobe,
  output logic [IDX_W-1:0]   slotSel
);

  localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ageQ [ENTRIES];
  logic [IDX_W-1:0] hitIdx;
  logic [IDX_W-1:0] victimIdx;
  logic             anyHit;
  logic             emptyFound;

  // Encode the single matching slot.
  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i]) hitIdx = IDX_W'(i);
    end
  end

  assign anyHit = |hitVec;

  // Replacement choice: lowest empty slot, else the oldest one.
  always_comb begin
    victimIdx  = '0;
    emptyFound = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!validVec[i] && !emptyFound) begin
        victimIdx  = IDX_W'(i);
        emptyFound = 1'b1;
      end
    end
    if (!emptyFound) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (ageQ[i] == AGE_MAX) victimIdx = IDX_W'(i);
      end
    end
  end

  // Lookup has priority; an insert in the same cycle is dropped.
  always_comb begin
    strobe  = '0;
    slotSel = victimIdx;
    if (lkValid) begin
      strobe.respond = 1'b1;
      strobe.hit     = anyHit;
      if (anyHit) begin
        strobe.write      = 1'b1;
        strobe.writeValid = dispValid;
        strobe.useDisp    = 1'b1;
        slotSel           = hitIdx;
      end
    end else if (insValid) begin
      strobe.write      = 1'b1;
      strobe.writeValid = 1'b1;
    end
  end

  // Ages stay a permutation of 0..ENTRIES-1; 0 is most recent.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) ageQ[i] <= IDX_W'(i);
    end else if (strobe.write) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == slotSel) ageQ[i] <= '0;
        else if (ageQ[i] < ageQ[slotSel]) ageQ[i] <= ageQ[i] + 1'b1;
      end
    end
  end

endmodule

// File: rtl/victim_store.sv
module victim_store
  import victim_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  vcStrobe_t          strobe,
  input  logic [IDX_W-1:0]   slotSel,
  input  logic [ADDR_W-1:0]  insAddr,
  input  logic [DATA_W-1:0]  insData,
  input  logic [ADDR_W-1:0]  lkAddr,
  input  logic [ADDR_W-1:0]  dispAddr,
  input  logic [DATA_W-1:0]  dispData,
  output logic [ENTRIES-1:0] hitVec,
  output logic [ENTRIES-1:0] validVec,
  output logic               respValid,
  output logic               respHit,
  output logic [DATA_W-1:0]  respData
);

  logic [ADDR_W-1:0] addrQ [ENTRIES];
  logic [DATA_W-1:0] dataQ [ENTRIES];
  logic [ENTRIES-1:0] validQ;

  assign validVec = validQ;

  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    assign hitVec[g] = validQ[g] && (addrQ[g] == lkAddr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= '0;
    else if (strobe.write) validQ[slotSel] <= strobe.writeValid;
  end

  always_ff @(posedge clk) begin
    if (strobe.write) begin
      addrQ[slotSel] <= strobe.useDisp ? dispAddr : insAddr;
      dataQ[slotSel] <= strobe.useDisp ? dispData : insData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respData  <= '0;
    end else begin
      respValid <= strobe.respond;
      respHit   <= strobe.hit;
      respData  <= strobe.hit ? dataQ[slotSel] : '0;
    end
  end

endmodule

// File: rtl/victim_buf.sv
module victim_buf
  import victim_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              insValid,
  input  logic [ADDR_W-1:0] insAddr,
  input  logic [DATA_W-1:0] insData,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic              dispValid,
  input  logic [ADDR_W-1:0] dispAddr,
  input  logic [DATA_W-1:0] dispData,
  output logic              respValid,
  output logic              respHit,
  output logic [DATA_W-1:0] respData
);

  localparam int IDX_W = $clog2(ENTRIES);

  vcStrobe_t          strobe;
  logic [IDX_W-1:0]   slotSel;
  logic [ENTRIES-1:0] hitVec;
  logic [ENTRIES-1:0] validVec;

  victim_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .insValid(insValid), .lkValid(lkValid), .dispValid(dispValid),
    .hitVec(hitVec), .validVec(validVec),
    .strobe(strobe), .slotSel(slotSel)
  );

  victim_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .slotSel(slotSel),
    .insAddr(insAddr), .insData(insData),
    .lkAddr(lkAddr), .dispAddr(dispAddr), .dispData(dispData),
    .hitVec(hitVec), .validVec(validVec),
    .respValid(respValid), .respHit(respHit), .respData(respData)
  );

endmodule

// File: rtl/victim_buf_chk.sv
module victim_buf_chk #(
  parameter int ENTRIES = 4,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               insValid,
  input logic               lkValid,
  input logic               dispValid,
  input logic [ENTRIES-1:0] hitVec,
  input logic [ENTRIES-1:0] validVec,
  input logic               respValid,
  input logic               respHit,
  input logic [DATA_W-1:0]  respData
);

  p_resp_follows_lookup_r2: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> respValid);

  p_no_spurious_resp_r2: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !respValid);

  p_hit_flag_matches_r2: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> (respHit == $past(hitVec != '0)));

  p_miss_data_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |-> (respData == '0));

  p_single_match_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  p_empty_swap_frees_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && (hitVec != '0) && !dispValid) |=>
      ($countones(validVec) + 1 == $countones($past(validVec))));

  p_insert_occupies_r6: assert property (@(posedge clk) disable iff (!rstN)
    (insValid && !lkValid) |=> (validVec != '0));

  p_miss_keeps_state_r9: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && (hitVec == '0)) |=> $stable(validVec));

endmodule

bind victim_buf victim_buf_chk #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .insValid(insValid), .lkValid(lkValid),
  .dispValid(dispValid), .hitVec(hitVec), .validVec(validVec),
  .respValid(respValid), .respHit(respHit), .respData(respData)
);

// File: tb/victim_buf_tb.sv
module victim_buf_tb;

  localparam int ENTRIES = 4;
  localparam int ADDR_W  = 26;
  localparam int DATA_W  = 32;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } line_t;

  typedef struct {
    logic              hit;
    logic [DATA_W-1:0] data;
    string             tag;
  } expect_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              insValid = 1'b0;
  logic [ADDR_W-1:0] insAddr = '0;
  logic [DATA_W-1:0] insData = '0;
  logic              lkValid = 1'b0;
  logic [ADDR_W-1:0] lkAddr = '0;
  logic              dispValid = 1'b0;
  logic [ADDR_W-1:0] dispAddr = '0;
  logic [DATA_W-1:0] dispData = '0;
  logic              respValid;
  logic              respHit;
  logic [DATA_W-1:0] respData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [ADDR_W-1:0] nextAddr = 26'h100;

  line_t   model[$];   // front = most recently used
  expect_t sb[$];

  always #10ns clk = ~clk;

  victim_buf #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN),
    .insValid(insValid), .insAddr(insAddr), .insData(insData),
    .lkValid(lkValid), .lkAddr(lkAddr),
    .dispValid(dispValid), .dispAddr(dispAddr), .dispData(dispData),
    .respValid(respValid), .respHit(respHit), .respData(respData)
  );

  function automatic logic [ADDR_W-1:0] freshAddr();
    nextAddr = nextAddr + 26'd7;
    return nextAddr;
  endfunction

  function automatic line_t freshLine();
    line_t l;
    l.addr = freshAddr();
    l.data = $urandom;
    return l;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One operation per cycle; expectations come from the recency list.
  task automatic doOp(input bit lk, input logic [ADDR_W-1:0] la,
                      input bit dv, input line_t d,
                      input bit ins, input line_t il, input string tag);
    expect_t e;
    int idx;
    lkValid = lk; lkAddr = la;
    dispValid = dv; dispAddr = d.addr; dispData = d.data;
    insValid = ins; insAddr = il.addr; insData = il.data;
    if (lk) begin
      idx = -1;
      foreach (model[i]) if (model[i].addr == la) idx = i;
      e.tag = tag;
      if (idx >= 0) begin
        e.hit = 1'b1; e.data = model[idx].data;
        model.delete(idx);
        if (dv) model.push_front(d);
      end else begin
        e.hit = 1'b0; e.data = '0;
      end
      sb.push_back(e);
    end else if (ins) begin
      if (model.size() == ENTRIES) void'(model.pop_back());
      model.push_front(il);
    end
    @(negedge clk);
    lkValid = 1'b0; insValid = 1'b0; dispValid = 1'b0;
  endtask

  task automatic insert(input line_t l, input string tag);
    line_t z;
    z.addr = '0; z.data = '0;
    doOp(1'b0, '0, 1'b0, z, 1'b1, l, tag);
  endtask

  task automatic lookup(input logic [ADDR_W-1:0] a, input bit dv, input line_t d,
                        input string tag);
    line_t z;
    z.addr = '0; z.data = '0;
    doOp(1'b1, a, dv, d, 1'b0, z, tag);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(respValid == 1'b0, "R1 respValid in reset", 64'(respValid), 0);
    model.delete();
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Monitor: compare each response against the oldest expectation.
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && respValid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2 unexpected response", 64'(respValid), 0);
        end else begin
          expect_t e;
          e = sb.pop_front();
          check(respHit == e.hit, {e.tag, " hit"}, 64'(respHit), 64'(e.hit));
          check(respData == e.data, {e.tag, " data"}, 64'(respData), 64'(e.data));
        end
      end
    end
  end

  initial begin
    #(20ns * 200000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    line_t none, a, b, x, y, n1, n2, held[ENTRIES];
    none.addr = '0; none.data = '0;

    // R1: empty after reset
    doReset();
    lookup(26'h3, 1'b0, none, "R1 lookup after reset");

    // R6: fill all slots, every line stays
    for (int i = 0; i < ENTRIES; i++) begin
      held[i] = freshLine();
      insert(held[i], "R6 fill");
    end
    // R2/R3/R4: hit returns data, displaced line swaps in
    n1 = freshLine();
    lookup(held[2].addr, 1'b1, n1, "R3 hit data");
    lookup(n1.addr, 1'b1, n1, "R4 displaced line present");
    lookup(held[2].addr, 1'b0, none, "R4 hit line removed");
    // R9: miss changes nothing, then R7: LRU insert order
    lookup(freshAddr(), 1'b0, none, "R9 miss");
    lookup(held[0].addr, 1'b1, held[0], "R7 touch oldest");
    n2 = freshLine();
    insert(n2, "R7 replace LRU");
    lookup(held[1].addr, 1'b1, held[1], "R7 LRU evicted");
    lookup(held[0].addr, 1'b1, held[0], "R8 touched line survives");
    // R5: empty-handed hit frees a slot; next insert fills it
    lookup(n1.addr, 1'b0, none, "R5 hit without displaced");
    lookup(n1.addr, 1'b0, none, "R5 slot now empty");
    insert(freshLine(), "R6 fill freed slot");
    lookup(held[3].addr, 1'b1, held[3], "R6 no eviction while empty");
    // R10: collision drops the insert
    n1 = freshLine();
    doOp(1'b1, held[0].addr, 1'b1, held[0], 1'b1, n1, "R10 lookup wins");
    lookup(n1.addr, 1'b0, none, "R10 dropped insert absent");

    // R11: conflicting pair ping-pong on a full buffer
    doReset();
    for (int i = 0; i < ENTRIES; i++) begin
      held[i] = freshLine();
      insert(held[i], "R11 preload");
    end
    a = freshLine(); b = freshLine();
    lookup(b.addr, 1'b1, a, "R11 B misses");
    insert(a, "R11 A evicted into buffer");
    lookup(held[0].addr, 1'b0, none, "R11 oldest evicted");
    for (int k = 0; k < 6; k++) begin
      lookup(a.addr, 1'b1, b, "R11 A swaps in");
      lookup(b.addr, 1'b1, a, "R11 B swaps in");
    end
    for (int i = 1; i < ENTRIES; i++) begin
      x = held[i];
      lookup(x.addr, 1'b1, x, "R8 others kept");
    end

    // Mixed traffic against the recency model
    doReset();
    for (int k = 0; k < 400; k++) begin
      int op;
      op = $urandom_range(0, 3);
      y = freshLine();
      if (model.size() == 0) op = 0;
      case (op)
        0: insert(y, "R7 random insert");
        1: begin
          x = model[$urandom_range(0, model.size() - 1)];
          lookup(x.addr, 1'($urandom_range(0, 1)), y, "R4 random hit");
        end
        2: lookup(freshAddr(), 1'b1, y, "R9 random miss");
        default: begin
          x = model[$urandom_range(0, model.size() - 1)];
          doOp(1'b1, x.addr, 1'b1, y, 1'b1, freshLine(), "R10 random collision");
        end
      endcase
    end

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R2 all responses seen", 64'(sb.size()), 0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule